// File: doc/BRIEF.md
# Reloadable Register-Programmed Clock Divider

This block divides a fast input clock by a software-chosen ratio. It produces a divided output clock that can be gated, and a one-cycle clock-enable strobe at the start of every output period. Software reaches it through a small synchronous register bus that holds two 32-bit words: a control word and a ratio word.

A ratio written into the ratio word is only staged. It does not reach the divider until software performs a two-step reload. First it sets the output's force bit in the control word. Then it sets the shared reload trigger, with the force bit still set. The staged value is clamped to one of the legal ratios 4, 5, 6 or 8. It is then held pending and becomes active at the next output period boundary, so the output never shows a shortened pulse. Afterwards software clears the low request bits, and neither the active ratio nor the enable is affected. A separate enable bit in the upper part of the control word gates the output.

Top module: `clk_ratio_div`

## Requirements
- R1: The control word is at address 0x0 and the ratio word is at address 0x8. Each reads back exactly the value last written. The ratio field is bits [13:8] of the ratio word. Any other address reads as zero.
- R2: After reset both words read zero, the active ratio is 4, and the clock output and the strobe are low.
- R3: Bit 25 of the control word enables the output. While it is clear, the clock output and the strobe stay low.
- R4: Writing the ratio word alone never changes the active division ratio.
- R5: A staged ratio is loaded only when control bit 8 (reload trigger) and control bit 1 (force for this output) are both set. Either bit alone, or bit 8 with a different force bit such as bit 0, has no effect.
- R6: Clearing control bits [8:0] after a reload keeps the active ratio and leaves the output enabled.
- R7: On load, a field value below 4 becomes 4 and a value of 7 or more becomes 8. The values 4, 5 and 6 are kept as written.
- R8: With active ratio N, the output period is N input cycles. The output is high for floor(N/2) cycles, then low for the rest of the period.
- R9: The strobe is high for exactly one input cycle per output period. That cycle is the first high cycle of the output.
- R10: A newly loaded ratio takes effect only at the end of the output period in progress. The period in which the reload happens keeps the old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| clk_out | output | 1 | Gated divided clock |
| clk_en_pulse | output | 1 | One-cycle strobe at the start of each output period |

## Verification
The bound checker watches every cycle. It checks that the active ratio is always one of the legal values, and that it changes only at a period boundary or while the output is disabled. It checks that the active ratio holds while no load is pending, and that the output stays low when disabled. It also checks that the strobe lasts one cycle and falls on a rising output. Other properties depend on a sequence of bus writes, and only the bench scenarios show them: the measured period and duty for each clamped ratio, the rejected partial reload handshakes, register readback, and the old length of the period in which a reload happens.

// File: rtl/clk_ratio_div.sv
module clk_ratio_div #(
  parameter int DW         = 32,
  parameter int AW         = 4,
  parameter int CTRL_ADDR  = 0,
  parameter int RATIO_ADDR = 8,
  parameter int FIELD_IDX  = 1,
  parameter int RATIO_LSB  = 8,
  parameter int RATIO_W    = 6,
  parameter int EN_BASE    = 24,
  parameter int TRIG_BIT   = 8,
  parameter int CNT_W      = 4,
  parameter int RST_RATIO  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          clk_out,
  output logic          clk_en_pulse
);
  localparam int EN_BIT = EN_BASE + FIELD_IDX;

  logic [DW-1:0]    ctrl_q, ratio_q;
  logic [CNT_W-1:0] act_q, pend_r, cnt_q, act_n, cnt_n;
  logic             pend_q, en, load, wrap, apply, out_n, pulse_n;

  function automatic logic [CNT_W-1:0] clamp(input logic [RATIO_W-1:0] f);
    if (f < RATIO_W'(4)) return CNT_W'(4);
    if (f >= RATIO_W'(7)) return CNT_W'(8);
    return CNT_W'(f);
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl_q  <= '0;
      ratio_q <= '0;
    end else if (wr_en) begin
      if (addr == AW'(CTRL_ADDR))  ctrl_q  <= wdata;
      if (addr == AW'(RATIO_ADDR)) ratio_q <= wdata;
    end

  assign rdata = (addr == AW'(CTRL_ADDR))  ? ctrl_q  :
                 (addr == AW'(RATIO_ADDR)) ? ratio_q : '0;

  assign en    = ctrl_q[EN_BIT];
  assign load  = ctrl_q[TRIG_BIT] & ctrl_q[FIELD_IDX];
  assign wrap  = en && (cnt_q == act_q - CNT_W'(1));
  assign apply = pend_q && (!en || wrap);
  assign act_n = apply ? pend_r : act_q;
  assign cnt_n = !en ? act_n - CNT_W'(1) : (wrap ? '0 : cnt_q + CNT_W'(1));
  assign out_n   = en && (cnt_n < (act_n >> 1));
  assign pulse_n = en && (cnt_n == '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend_q <= 1'b0;
      pend_r <= CNT_W'(RST_RATIO);
    end else if (load) begin
      pend_q <= 1'b1;
      pend_r <= clamp(ratio_q[RATIO_LSB +: RATIO_W]);
    end else if (apply) begin
      pend_q <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      act_q        <= CNT_W'(RST_RATIO);
      cnt_q        <= CNT_W'(RST_RATIO - 1);
      clk_out      <= 1'b0;
      clk_en_pulse <= 1'b0;
    end else begin
      act_q        <= act_n;
      cnt_q        <= cnt_n;
      clk_out      <= out_n;
      clk_en_pulse <= pulse_n;
    end
endmodule

// File: rtl/clk_ratio_div_chk.sv
module clk_ratio_div_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             pend,
  input logic [CNT_W-1:0] act,
  input logic [CNT_W-1:0] cnt,
  input logic             clk_out,
  input logic             pulse
);
  p_legal_ratio_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (act == 4 || act == 5 || act == 6 || act == 8));

  p_low_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!clk_out && !pulse));

  p_hold_without_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !pend |=> $stable(act));

  p_boundary_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act) |-> $past(!en || (cnt == act - CNT_W'(1))));

  p_pulse_on_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> (clk_out && !$past(clk_out)));

  p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
endmodule

bind clk_ratio_div clk_ratio_div_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .en(en), .pend(pend_q), .act(act_q),
  .cnt(cnt_q), .clk_out(clk_out), .pulse(clk_en_pulse)
);

// File: tb/clk_ratio_div_tb_top.sv
`timescale 1ns/1ps
module clk_ratio_div_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        clk_out, clk_en_pulse;

  int checks = 0, fails = 0;

  localparam int NV = 9;
  localparam int RAW [NV] = '{4, 5, 6, 8, 0, 3, 7, 9, 63};
  localparam int EXP [NV] = '{4, 5, 6, 8, 4, 4, 8, 8, 8};

  localparam logic [31:0] EN    = 32'h1 << 25;
  localparam logic [31:0] FORCE = 32'h1 << 1;
  localparam logic [31:0] TRIG  = 32'h1 << 8;

  always #5 clk = ~clk;

  clk_ratio_div dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .clk_out(clk_out), .clk_en_pulse(clk_en_pulse)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic sync_pulse();
    int n = 0;
    @(negedge clk);
    while (!clk_en_pulse && n < 100) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic measure(output int len, output int hi, output bit out_at_pulse);
    len = 0; hi = 0;
    out_at_pulse = clk_out;
    do begin
      if (clk_out) hi++;
      len++;
      @(negedge clk);
    end while (!clk_en_pulse && len < 64);
  endtask

  task automatic period_check(input int exp, input string req);
    int len, hi;
    bit op;
    sync_pulse();
    measure(len, hi, op);
    check(len == exp, req, len, exp);
    check(hi == exp / 2, "R8 high phase", hi, exp / 2);
    check(op == 1'b1, "R9 strobe on output high", op, 1);
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int prev;
    repeat (3) @(negedge clk);
    // R2 reset state
    check(clk_out == 1'b0, "R2 clk_out", clk_out, 0);
    check(clk_en_pulse == 1'b0, "R2 strobe", clk_en_pulse, 0);
    rst_n = 1'b1;
    rd(4'h0, d); check(d == 0, "R2 ctrl reset", d, 0);
    rd(4'h8, d); check(d == 0, "R2 ratio reset", d, 0);
    rd(4'h4, d); check(d == 0, "R1 unmapped address", d, 0);
    repeat (5) @(negedge clk);
    check(clk_out == 1'b0, "R3 disabled low", clk_out, 0);

    wr(4'h0, EN);
    period_check(4, "R2 default ratio 4");

    // R4: staging only
    wr(4'h8, 32'd6 << 8);
    rd(4'h8, d); check(d == (32'd6 << 8), "R1 ratio readback", d, 6 << 8);
    period_check(4, "R4 staged ratio not applied");
    // R5: trigger without force, force without trigger, wrong force bit
    wr(4'h0, EN | TRIG);
    repeat (10) @(negedge clk);
    period_check(4, "R5 trigger alone");
    wr(4'h0, EN | FORCE);
    repeat (10) @(negedge clk);
    period_check(4, "R5 force alone");
    wr(4'h0, EN | TRIG | 32'h1);
    repeat (10) @(negedge clk);
    period_check(4, "R5 wrong force bit");
    wr(4'h0, EN);

    prev = 4;
    for (int i = 0; i < NV; i++) begin
      int len, hi;
      bit op;
      wr(4'h8, 32'(RAW[i]) << 8);
      wr(4'h0, EN | FORCE);
      sync_pulse();
      fork
        measure(len, hi, op);
        wr(4'h0, EN | FORCE | TRIG);
      join
      check(len == prev, "R10 reload period keeps old length", len, prev);
      wr(4'h0, EN);
      rd(4'h0, d); check(d == EN, "R6 ctrl after clear", d, EN);
      period_check(EXP[i], "R7 R8 clamped period");
      period_check(EXP[i], "R6 ratio kept after clear");
      rd(4'h8, d);
      check(d == (32'(RAW[i]) << 8), "R1 ratio readback", d, RAW[i] << 8);
      prev = EXP[i];
    end

    // R3: disable holds output low
    wr(4'h0, 32'h0);
    @(negedge clk);
    begin
      int seen = 0;
      for (int k = 0; k < 30; k++) begin
        @(negedge clk);
        if (clk_out || clk_en_pulse) seen++;
      end
      check(seen == 0, "R3 disabled output low", seen, 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule